// File: doc/BRIEF.md
# Dual-Mode Single-Precision Multiplier

This block multiplies two 32-bit binary floating-point operands and returns a registered 32-bit product with status flags. A per-operation mode bit chooses between two arithmetic models. In the standard model, the full set of encodings is honoured: signed zeros, subnormal inputs and outputs, infinities and quiet NaN. In the graphics model, no NaN, infinity or subnormal value can appear. Any operand with a zero exponent field counts as zero. Any operand with an all-ones exponent field counts as the largest finite number of its sign. Results that leave the normal range are clamped instead of being produced as special encodings.

Two further inputs clear the sign of either operand before anything else happens. This gives special-function pipelines an absolute-value path, so that their arguments are never negative. Rounding is round-to-nearest, ties-to-even, in both models. Each accepted operation produces its result one clock later, together with a valid strobe.

Top module: `fmul_alt`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, out_valid, out_res, out_ovf, out_unf and out_inv are all zero.
- R2: out_valid equals in_valid of the previous cycle. out_res and the three flags load only on cycles with in_valid high and hold their values otherwise.
- R3: In standard mode (alt_mode=0), a product of finite nonzero operands is rounded to nearest-even. Bit 31 is the sign, bits 30:23 are the biased exponent (bias 127) and bits 22:0 are the fraction.
- R4: In standard mode, subnormal operands (exponent field 0) are used at their true value, and tiny results are rounded as subnormals. out_unf is raised when both operands are finite and nonzero and the exact product magnitude is below 2^-126.
- R5: In standard mode, a finite product that rounds to a magnitude of 2^128 or more becomes a signed infinity (exponent field 0xFF, fraction 0), with out_ovf raised.
- R6: In standard mode, a NaN operand gives 0x7FC00000. Infinity times zero gives 0x7FC00000 with out_inv raised. Infinity times a nonzero non-NaN value gives an infinity with the XOR of the signs and no flag. Zero times a finite value gives a zero with the XOR of the signs.
- R7: In graphics mode (alt_mode=1), an operand whose exponent field is 0 makes the result 0x00000000 with no flags, whatever the other operand is.
- R8: In graphics mode, an operand whose exponent field is 0xFF is used as the maximum finite magnitude 0x7F7FFFFF with its own sign. Other products are rounded as in R3.
- R9: In graphics mode, a product that rounds beyond the finite range gives the sign of the product with magnitude 0x7F7FFFFF, and out_ovf is raised.
- R10: In graphics mode, a nonzero product whose exact magnitude is below 2^-126 gives the sign of the product with magnitude 0x00800000, and out_unf is raised.
- R11: In graphics mode the result never has exponent field 0xFF, never has exponent field 0 unless the whole word is zero, and out_inv stays low.
- R12: abs_a and abs_b clear the sign bit of in_a and in_b respectively before any other processing, in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation request |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| alt_mode | input | 1 | 1 selects the graphics model, 0 the standard model |
| abs_a | input | 1 | Clear the sign of in_a |
| abs_b | input | 1 | Clear the sign of in_b |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_res | output | 32 | Product |
| out_ovf | output | 1 | Overflow or saturation occurred |
| out_unf | output | 1 | Exact product was below the normal range |
| out_inv | output | 1 | Infinity times zero in standard mode |

## Verification
The stimulus concentrates on exponent sums close to both ends of the range. That is where a design with an off-by-one exponent bias would send a product that belongs at the largest finite value to infinity, or would clamp a result that is still representable. Products that land exactly halfway between two neighbours are aimed at, because a design that rounds ties away from zero gets them wrong by one unit in the last place. Near 2^-126 the bench pairs operands so that the rounding carry is checked both when it lifts a subnormal into the normal range and when it does not. A design that shifts the wrong amount there returns the wrong subnormal fraction, or drops the sticky bits. In graphics mode the bench feeds subnormal, infinite and NaN encodings to show they are flushed or clamped, and negative zeros to show that the zero result carries no sign.

// File: rtl/fmul_alt_pkg.sv
package fmul_alt_pkg;
   // Operand class after decoding; the graphics model never yields INF or NAN.
   typedef enum logic [1:0] {
      CLS_ZERO = 2'd0,
      CLS_FIN  = 2'd1,
      CLS_INF  = 2'd2,
      CLS_NAN  = 2'd3
   } fcls_e;
endpackage

// File: rtl/fmul_alt_unpack.sv
module fmul_alt_unpack
   import fmul_alt_pkg::*;
#(
   parameter int EW = 8,
   parameter int MW = 23
)(
   input  logic                    [EW+MW:0] word,
   input  logic                              alt,
   input  logic                              abs_en,
   output logic                              sign,
   output fcls_e                             cls,
   output logic                    [MW:0]    sig,
   output logic signed             [EW+2:0]  expo
);
   localparam int XW  = EW + 3;
   localparam int LZW = $clog2(MW + 1);
   localparam logic [EW-1:0] E_ONES = '1;
   localparam logic [EW-1:0] E_TOP  = E_ONES - 1'b1;

   logic [EW-1:0]  ef;
   logic [MW-1:0]  ff;
   logic [LZW-1:0] lz;

   always_comb begin
      ef   = word[EW+MW-1:MW];
      ff   = word[MW-1:0];
      sign = word[EW+MW] & ~abs_en;
      // shift that brings the leading one of a subnormal fraction to bit MW
      lz = '0;
      for (int i = 0; i < MW; i++) begin
         if (ff[i]) lz = LZW'(MW - i);
      end
      sig  = '0;
      expo = '0;
      cls  = CLS_FIN;
      if (ef == '0) begin
         if (alt || ff == '0) begin
            cls = CLS_ZERO;
         end else begin
            sig  = {1'b0, ff} << lz;
            expo = XW'(1) - XW'(lz);
         end
      end else if (ef == E_ONES) begin
         if (alt) begin
            sig  = '1;
            expo = XW'(E_TOP);
         end else if (ff == '0) begin
            cls = CLS_INF;
         end else begin
            cls = CLS_NAN;
         end
      end else begin
         sig  = {1'b1, ff};
         expo = XW'(ef);
      end
   end
endmodule

// File: rtl/fmul_alt_core.sv
module fmul_alt_core #(
   parameter int EW = 8,
   parameter int MW = 23
)(
   input  logic        [MW:0]        sig_a,
   input  logic        [MW:0]        sig_b,
   input  logic signed [EW+2:0]      exp_a,
   input  logic signed [EW+2:0]      exp_b,
   output logic        [2*MW+1:0]    norm,
   output logic signed [EW+2:0]      er
);
   localparam int FW   = MW + 1;
   localparam int PW   = 2 * FW;
   localparam int XW   = EW + 3;
   localparam int BIAS = (1 << (EW - 1)) - 1;

   logic [PW-1:0] prod;
   logic          top;

   always_comb begin
      prod = {{FW{1'b0}}, sig_a} * {{FW{1'b0}}, sig_b};
      top  = prod[PW-1];
      // leading one placed at bit PW-1; er is the biased exponent of the exact product
      norm = top ? prod : (prod << 1);
      er   = exp_a + exp_b - XW'(BIAS) + $signed({{(XW-1){1'b0}}, top});
   end
endmodule

// File: rtl/fmul_alt_pack.sv
module fmul_alt_pack
   import fmul_alt_pkg::*;
#(
   parameter int EW = 8,
   parameter int MW = 23
)(
   input  logic                  sign_a,
   input  logic                  sign_b,
   input  fcls_e                 cls_a,
   input  fcls_e                 cls_b,
   input  logic                  alt,
   input  logic [2*MW+1:0]       norm,
   input  logic signed [EW+2:0]  er,
   output logic [EW+MW:0]        res,
   output logic                  ovf,
   output logic                  unf,
   output logic                  inv
);
   localparam int FW = MW + 1;
   localparam int PW = 2 * FW;
   localparam int XW = EW + 3;
   localparam logic [EW-1:0]    E_ONES = '1;
   localparam logic [EW-1:0]    E_TOP  = E_ONES - 1'b1;
   localparam logic [EW-1:0]    E_MIN  = EW'(1);
   localparam logic [EW+MW:0]   QNAN   = {1'b0, E_ONES, 1'b1, {(MW-1){1'b0}}};

   logic                 res_sign, tiny, rnd_up, guard, sticky, lost, big;
   logic                 any_zero, any_inf, any_nan, bad_pair;
   logic [XW-1:0]        sh;
   logic [PW-1:0]        shd, mask;
   logic [FW-1:0]        kept;
   logic [FW:0]          rsig;
   logic signed [XW-1:0] efin;
   logic [EW-1:0]        efield;
   logic [EW+MW:0]       fin_word;

   always_comb begin
      res_sign = sign_a ^ sign_b;
      tiny     = (er < XW'(1));
      sh       = tiny ? (XW'(1) - er) : '0;
      shd      = norm >> sh;
      mask     = ~({PW{1'b1}} << sh);
      lost     = |(norm & mask);
      kept     = shd[PW-1:FW];
      guard    = shd[FW-1];
      sticky   = (|shd[FW-2:0]) | lost;
      rnd_up   = guard & (sticky | kept[0]);
      rsig     = {1'b0, kept} + {{FW{1'b0}}, rnd_up};
      efin     = er + $signed({{(XW-1){1'b0}}, rsig[FW]});
      big      = !tiny && (efin >= $signed({3'b000, E_ONES}));
      efield   = tiny ? {{(EW-1){1'b0}}, rsig[MW]} : efin[EW-1:0];
      fin_word = {res_sign, efield, rsig[MW-1:0]};

      any_zero = (cls_a == CLS_ZERO) || (cls_b == CLS_ZERO);
      any_inf  = (cls_a == CLS_INF)  || (cls_b == CLS_INF);
      any_nan  = (cls_a == CLS_NAN)  || (cls_b == CLS_NAN);
      bad_pair = any_zero && any_inf;

      res = fin_word;
      ovf = 1'b0;
      unf = 1'b0;
      inv = 1'b0;
      if (alt) begin
         if (any_zero) begin
            res = '0;
         end else if (big) begin
            res = {res_sign, E_TOP, {MW{1'b1}}};
            ovf = 1'b1;
         end else if (tiny) begin
            res = {res_sign, E_MIN, {MW{1'b0}}};
            unf = 1'b1;
         end
      end else begin
         if (any_nan) begin
            res = QNAN;
         end else if (bad_pair) begin
            res = QNAN;
            inv = 1'b1;
         end else if (any_inf) begin
            res = {res_sign, E_ONES, {MW{1'b0}}};
         end else if (any_zero) begin
            res = {res_sign, {(EW+MW){1'b0}}};
         end else if (big) begin
            res = {res_sign, E_ONES, {MW{1'b0}}};
            ovf = 1'b1;
         end else begin
            unf = tiny;
         end
      end
   end
endmodule

// File: rtl/fmul_alt.sv
module fmul_alt
   import fmul_alt_pkg::*;
#(
   parameter int EW = 8,
   parameter int MW = 23
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [EW+MW:0]   in_a,
   input  logic [EW+MW:0]   in_b,
   input  logic             alt_mode,
   input  logic             abs_a,
   input  logic             abs_b,
   output logic             out_valid,
   output logic [EW+MW:0]   out_res,
   output logic             out_ovf,
   output logic             out_unf,
   output logic             out_inv
);
   localparam int XW = EW + 3;
   localparam int WW = EW + MW + 1;

   if (EW < 3 || MW < 3) begin : g_bad_width
      $error("fmul_alt: EW and MW must both be 3 or more");
   end

   logic [1:0][WW-1:0]   op_w;
   logic [1:0]           op_abs;
   logic [1:0]           op_sgn;
   fcls_e                op_cls [2];
   logic [MW:0]          op_sig [2];
   logic signed [XW-1:0] op_exp [2];

   assign op_w[0]   = in_a;
   assign op_w[1]   = in_b;
   assign op_abs[0] = abs_a;
   assign op_abs[1] = abs_b;

   for (genvar g = 0; g < 2; g++) begin : g_unp
      fmul_alt_unpack #(.EW(EW), .MW(MW)) u_unp (
         .word   (op_w[g]),
         .alt    (alt_mode),
         .abs_en (op_abs[g]),
         .sign   (op_sgn[g]),
         .cls    (op_cls[g]),
         .sig    (op_sig[g]),
         .expo   (op_exp[g])
      );
   end

   logic [2*MW+1:0]      norm;
   logic signed [XW-1:0] er;
   logic [WW-1:0]        res;
   logic                 ovf, unf, inv;

   fmul_alt_core #(.EW(EW), .MW(MW)) u_core (
      .sig_a (op_sig[0]),
      .sig_b (op_sig[1]),
      .exp_a (op_exp[0]),
      .exp_b (op_exp[1]),
      .norm  (norm),
      .er    (er)
   );

   fmul_alt_pack #(.EW(EW), .MW(MW)) u_pack (
      .sign_a (op_sgn[0]),
      .sign_b (op_sgn[1]),
      .cls_a  (op_cls[0]),
      .cls_b  (op_cls[1]),
      .alt    (alt_mode),
      .norm   (norm),
      .er     (er),
      .res    (res),
      .ovf    (ovf),
      .unf    (unf),
      .inv    (inv)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_res   <= '0;
         out_ovf   <= 1'b0;
         out_unf   <= 1'b0;
         out_inv   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_res <= res;
            out_ovf <= ovf;
            out_unf <= unf;
            out_inv <= inv;
         end
      end
   end
endmodule

// File: rtl/fmul_alt_chk.sv
module fmul_alt_chk #(
   parameter int EW = 8,
   parameter int MW = 23
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [EW+MW:0]   in_a,
   input  logic [EW+MW:0]   in_b,
   input  logic             alt_mode,
   input  logic             abs_a,
   input  logic             abs_b,
   input  logic             out_valid,
   input  logic [EW+MW:0]   out_res,
   input  logic             out_ovf,
   input  logic             out_unf,
   input  logic             out_inv
);
   localparam int TOP = EW + MW;
   localparam logic [EW-1:0] E_ONES = '1;
   localparam logic [EW-1:0] E_TOP  = E_ONES - 1'b1;
   localparam logic [TOP:0]  QNAN   = {1'b0, E_ONES, 1'b1, {(MW-1){1'b0}}};

   assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_res) && $stable(out_ovf) && $stable(out_unf) && $stable(out_inv)));
   assert_ieee_inf_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !alt_mode) |=> (!out_ovf || out_res[TOP-1:0] == {E_ONES, {MW{1'b0}}}));
   assert_ieee_nan_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !alt_mode && in_a[TOP-1:MW] == E_ONES && in_a[MW-1:0] != '0)
      |=> (out_res == QNAN && !out_inv));
   assert_alt_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && alt_mode && (in_a[TOP-1:MW] == '0 || in_b[TOP-1:MW] == '0))
      |=> (out_res == '0 && !out_ovf && !out_unf));
   assert_alt_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && alt_mode) |=> (!out_ovf || out_res[TOP-1:0] == {E_TOP, {MW{1'b1}}}));
   assert_alt_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && alt_mode) |=> (!out_unf || out_res[TOP-1:0] == {EW'(1), {MW{1'b0}}}));
   assert_alt_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && alt_mode) |=> (out_res[TOP-1:MW] != E_ONES && !out_inv &&
                                  (out_res[TOP-1:MW] != '0 || out_res == '0)));
   assert_abs_sign_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && abs_a && abs_b) |=> !out_res[TOP]);
endmodule

bind fmul_alt fmul_alt_chk #(.EW(EW), .MW(MW)) u_chk (.*);

// File: tb/tb_fmul_alt.sv
module tb_fmul_alt;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_a = '0, in_b = '0;
   logic        alt_mode = 1'b0, abs_a = 1'b0, abs_b = 1'b0;
   logic        out_valid;
   logic [31:0] out_res;
   logic        out_ovf, out_unf, out_inv;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;

   always #5 clk = ~clk;

   fmul_alt dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
      .alt_mode(alt_mode), .abs_a(abs_a), .abs_b(abs_b), .out_valid(out_valid),
      .out_res(out_res), .out_ovf(out_ovf), .out_unf(out_unf), .out_inv(out_inv)
   );

   // magnitude of a finite encoding as an exact real
   function automatic real mag_of(input logic [31:0] w);
      int  e;
      real m;
      e = int'(w[30:23]);
      m = real'(w[22:0]);
      if (e == 0) return m * 2.0 ** (-149);
      return (m + 8388608.0) * 2.0 ** (e - 150);
   endfunction

   // round an exact nonzero magnitude to single precision; result {inv,unf,ovf,word}
   function automatic logic [34:0] round_ref(input real mag, input logic s, input bit alt);
      logic [63:0] d, sg, kept, r;
      int          eb, drop;
      bit          g, st;
      d  = $realtobits(mag);
      eb = int'(d[62:52]) - 1023 + 127;
      sg = {11'd0, 1'b1, d[51:0]};
      if (alt && eb < 1) return {3'b010, s, 8'h01, 23'h0};
      drop = (eb >= 1) ? 29 : 30 - eb;
      if (drop > 60) begin
         kept = '0; g = 1'b0; st = 1'b1;
      end else begin
         kept = sg >> drop;
         g    = sg[drop-1];
         st   = (sg & ((64'd1 << (drop - 1)) - 64'd1)) != 64'd0;
      end
      r = kept + ((g && (st || kept[0])) ? 64'd1 : 64'd0);
      if (eb >= 1) begin
         if (r[24]) begin
            eb = eb + 1;
            r  = r >> 1;
         end
         if (eb >= 255) return alt ? {3'b001, s, 31'h7F7FFFFF} : {3'b001, s, 31'h7F800000};
         return {3'b000, s, eb[7:0], r[22:0]};
      end
      return {3'b010, s, 7'h00, r[23], r[22:0]};
   endfunction

   function automatic logic [34:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                          input bit alt, input bit aa, input bit ab);
      logic [31:0] x, y;
      logic        s;
      bit          na, nb, ia, ib, za, zb;
      x = a; y = b;
      if (aa) x[31] = 1'b0;
      if (ab) y[31] = 1'b0;
      s = x[31] ^ y[31];
      if (alt) begin
         if (x[30:23] == 8'h00 || y[30:23] == 8'h00) return 35'h0;
         if (x[30:23] == 8'hFF) x = {x[31], 31'h7F7FFFFF};
         if (y[30:23] == 8'hFF) y = {y[31], 31'h7F7FFFFF};
      end else begin
         na = (x[30:23] == 8'hFF) && (x[22:0] != 0);
         nb = (y[30:23] == 8'hFF) && (y[22:0] != 0);
         ia = (x[30:23] == 8'hFF) && (x[22:0] == 0);
         ib = (y[30:23] == 8'hFF) && (y[22:0] == 0);
         za = (x[30:0] == 0);
         zb = (y[30:0] == 0);
         if (na || nb) return {3'b000, 32'h7FC00000};
         if ((ia && zb) || (za && ib)) return {3'b100, 32'h7FC00000};
         if (ia || ib) return {3'b000, s, 31'h7F800000};
         if (za || zb) return {3'b000, s, 31'h0};
      end
      return round_ref(mag_of(x) * mag_of(y), s, alt);
   endfunction

   function automatic string tag_for(input logic [34:0] e, input bit alt,
                                     input logic [31:0] a, input logic [31:0] b);
      if (alt) begin
         if (a[30:23] == 8'h00 || b[30:23] == 8'h00) return "R7";
         if (e[32]) return "R9";
         if (e[33]) return "R10";
         return "R8";
      end
      if (e[34]) return "R6";
      if (e[32]) return "R5";
      if (e[30:23] == 8'hFF) return "R6";
      if (e[33]) return "R4";
      return "R3";
   endfunction

   task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp_v);
      n_chk++;
      if (act !== exp_v) begin
         n_fail++;
         $display("FAIL %s a=%h b=%h alt=%0d got {v,inv,unf,ovf,res}=%h expected %h",
                  req, in_a, in_b, alt_mode, act, exp_v);
      end
   endtask

   task automatic check_bit(input string req, input bit ok, input string what);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got res=%h v=%0d flags=%b%b%b expected condition true",
                  req, what, out_res, out_valid, out_inv, out_unf, out_ovf);
      end
   endtask

   // apply one operation at a falling edge, check it at the next falling edge
   task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit alt,
                         input bit aa, input bit ab, input string tag);
      logic [34:0] e;
      string       t;
      in_a = a; in_b = b; alt_mode = alt; abs_a = aa; abs_b = ab; in_valid = 1'b1;
      e = ref_mul(a, b, alt, aa, ab);
      t = (tag == "") ? tag_for(e, alt, a, b) : tag;
      @(negedge clk);
      check(t, {out_valid, out_inv, out_unf, out_ovf, out_res}, {1'b1, e});
      if (alt)
         check_bit("R11", out_res[30:23] != 8'hFF && !out_inv &&
                   (out_res[30:23] != 8'h00 || out_res == 32'h0), "alt encoding");
   endtask

   function automatic logic [31:0] pick_f();
      logic [31:0] r;
      int          sel;
      r   = $urandom;
      sel = int'($urandom % 11);
      case (sel)
         0:       begin r[30:23] = 8'h00; if ($urandom % 3 == 0) r[22:0] = '0; end
         1:       begin r[30:23] = 8'hFF; if ($urandom % 2 == 0) r[22:0] = '0; end
         2, 3:    r[30:23] = 8'(40 + $urandom % 51);
         4:       r[30:23] = 8'(225 + $urandom % 30);
         5:       r[30:23] = 8'(1 + $urandom % 12);
         6:       begin r[30:23] = 8'(100 + $urandom % 55); r[11:0] = '0; end
         default: r[30:23] = 8'(100 + $urandom % 55);
      endcase
      return r;
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL R2 watchdog: got no completion after %0d cycles expected completion", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] held;
      void'($urandom(32'd20240613));
      repeat (3) @(negedge clk);
      check("R1", {out_valid, out_inv, out_unf, out_ovf, out_res}, 36'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {out_valid, out_inv, out_unf, out_ovf, out_res}, 36'h0);

      // standard model, directed
      run_op(32'h3F800000, 32'h3F800000, 0, 0, 0, "R3");   // 1*1
      run_op(32'h3FC00000, 32'h3FC00000, 0, 0, 0, "R3");   // 1.5*1.5
      run_op(32'h3F800800, 32'h3F800800, 0, 0, 0, "R3");   // exact tie, stays even
      run_op(32'h3F800801, 32'h3F800800, 0, 0, 0, "R3");   // just above a tie
      run_op(32'h00000001, 32'h40000000, 0, 0, 0, "R4");   // subnormal times 2
      run_op(32'h00800000, 32'h3F000000, 0, 0, 0, "R4");   // min normal halved
      run_op(32'h00FFFFFF, 32'h3F000000, 0, 0, 0, "R4");   // carry back into normal
      run_op(32'h7F7FFFFF, 32'h40000000, 0, 0, 0, "R5");   // overflow to +inf
      run_op(32'hFF7FFFFF, 32'h7F7FFFFF, 0, 0, 0, "R5");   // overflow to -inf
      run_op(32'h7F800000, 32'h00000000, 0, 0, 0, "R6");   // inf*0
      run_op(32'h7FA00001, 32'h3F800000, 0, 0, 0, "R6");   // NaN in
      run_op(32'hFF800000, 32'h00000001, 0, 0, 0, "R6");   // -inf * subnormal
      run_op(32'h80000000, 32'h3F800000, 0, 0, 0, "R6");   // -0 * 1
      // graphics model, directed
      run_op(32'h80000000, 32'h40A00000, 1, 0, 0, "R7");   // -0 * 5 -> +0
      run_op(32'h00000001, 32'h7F7FFFFF, 1, 0, 0, "R7");   // subnormal flushed
      run_op(32'h7F800000, 32'h00000000, 1, 0, 0, "R7");   // inf*0 -> 0
      run_op(32'h7F800000, 32'h3F800000, 1, 0, 0, "R8");   // inf -> max finite
      run_op(32'hFFC00000, 32'h3F000000, 1, 0, 0, "R8");   // NaN code -> -max * 0.5
      run_op(32'h7F7FFFFF, 32'hC0000000, 1, 0, 0, "R9");   // saturate negative
      run_op(32'h00800000, 32'h3F000000, 1, 0, 0, "R10");  // clamp to min normal
      run_op(32'h80FFFFFF, 32'h3F000000, 1, 0, 0, "R10");  // negative clamp
      // absolute-value path
      run_op(32'hC0000000, 32'hC0400000, 0, 1, 0, "R12");  // |-2| * -3
      run_op(32'hC0000000, 32'hC0400000, 1, 1, 1, "R12");
      run_op(32'h80000000, 32'hBF800000, 0, 1, 1, "R12");

      // result holds while in_valid is low
      held = out_res;
      in_valid = 1'b0;
      in_a = 32'h40400000; in_b = 32'h40400000;
      @(negedge clk);
      check("R2", {out_valid, out_inv, out_unf, out_ovf, out_res}, {1'b0, 3'b000, held});

      // random, back to back
      for (int i = 0; i < 6000; i++) begin
         run_op(pick_f(), pick_f(), bit'($urandom % 2), bit'($urandom % 4 == 0),
                bit'($urandom % 4 == 0), "");
      end
      in_valid = 1'b0;
      @(negedge clk);
      check_bit("R2", !out_valid, "valid drop");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule